// File: doc/BRIEF.md
# Round-Trip Comma Latency Meter

This block measures the round-trip delay of a serial link in parallel byte-clock cycles. It watches two byte-wide parallel streams, each carrying 8 data bits and a control-character flag. The first is the word handed to the transmitter and the second is the word recovered by the receiver. A K28.5 comma on the outgoing stream starts a cycle counter. The next K28.5 comma on the incoming stream stops it, and the elapsed count is latched into a result register.

Both streams share one clock here, so the transmit clock is taken as frequency-locked to the recovered clock. Because the real transmit and receive sides are asynchronous, a count can be off from the true latency by up to two clock periods. A small read port gives a management interface two words: the latched result and a status word holding busy, valid and timeout. If no return comma arrives before the counter runs out, the block flags a timeout and latches the all-ones count.

Measurements are gated by an enable input. A one-cycle clear pulse, or a rising edge on enable, rearms the block after a result. A result stays readable until the next measurement completes.

Top module: `rtt_latency_meter`

## Requirements
- R1: After reset, busy_o, valid_o and timeout_o are low, result_o is zero, and the status word reads zero.
- R2: A comma is a word with the K flag set and data 0xBC. A word with the K flag clear and data 0xBC, or a K-flagged 0x3C, never starts a measurement.
- R3: While enable_i is low and the block is idle, a transmit comma does not start a measurement and busy_o stays low.
- R4: A transmit comma sampled in idle with enable_i high and clear_i low raises busy_o from the next cycle.
- R5: Suppose the start comma is sampled at edge a and the first later receive comma at edge b. Then from the cycle after edge b, valid_o is high, busy_o is low and result_o equals b-a.
- R6: A receive comma in the same cycle as the start comma, or while idle, has no effect.
- R7: A transmit comma seen while counting neither restarts the count nor alters the result.
- R8: If no receive comma arrives in the 2^CNT_W-1 cycles after the start, timeout_o rises, valid_o stays low and result_o becomes all ones. busy_o is still high one cycle earlier.
- R9: A clear pulse returns the block to idle, lowering valid_o and timeout_o, and keeps result_o. A clear in the same cycle as a transmit comma prevents the start.
- R10: With a result held, dropping enable_i keeps valid_o high. The next rising edge of enable_i rearms the block and lowers valid_o.
- R11: Dropping enable_i while counting aborts to idle. busy_o falls, valid_o stays low and result_o keeps the previous value.
- R12: At most one of busy_o, valid_o and timeout_o is high at any time.
- R13: With rd_addr_i = 0, rd_data_o is the result. With rd_addr_i = 1, bit 0 is busy, bit 1 is valid, bit 2 is timeout, and the upper bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Measurement enable; a rising edge rearms |
| clear_i | input | 1 | One-cycle rearm pulse |
| tx_data_i | input | 8 | Transmit-path data byte |
| tx_k_i | input | 1 | Transmit-path control-character flag |
| rx_data_i | input | 8 | Receive-path data byte |
| rx_k_i | input | 1 | Receive-path control-character flag |
| rd_addr_i | input | 1 | Management read select: 0 result, 1 status |
| rd_data_o | output | CNT_W | Management read data |
| busy_o | output | 1 | Measurement in progress |
| valid_o | output | 1 | Result complete, no timeout |
| timeout_o | output | 1 | No return comma before count limit |
| result_o | output | CNT_W | Latched round-trip count |

## Verification
The bench builds the meter with CNT_W = 6, so the count limit is 63 cycles. This puts the timeout and all-ones latch within a few dozen cycles, and lets a valid result of 62, one short of the limit, be checked next to it. The 20-bit default is left to elaboration only. At that width a timeout would take about a million cycles per case.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } rtt_state_e;

  localparam int          BYTE_W     = 8;
  localparam logic [7:0]  COMMA_BYTE = 8'hBC;
endpackage

// File: rtl/rtt_comma_det.sv
module rtt_comma_det #(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] CODE   = '1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              k_i,
  output logic              hit_o
);
  assign hit_o = k_i && (data_i == CODE);
endmodule

// File: rtl/rtt_ctrl.sv
module rtt_ctrl
  import rtt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic clear_i,
  input  logic tx_hit_i,
  input  logic rx_hit_i,
  input  logic sat_i,
  output logic start_o,
  output logic cap_o,
  output logic cap_to_o,
  output logic busy_o,
  output logic valid_o,
  output logic timeout_o
);
  rtt_state_e state_q, state_d;
  logic       en_q;
  logic       to_q;
  logic       rearm;

  assign rearm = clear_i || (enable_i && !en_q);

  always_comb begin
    state_d  = state_q;
    start_o  = 1'b0;
    cap_o    = 1'b0;
    cap_to_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (enable_i && !clear_i && tx_hit_i) begin
          state_d = ST_COUNT;
          start_o = 1'b1;
        end
      end
      ST_COUNT: begin
        if (clear_i || !enable_i) begin
          state_d = ST_IDLE;
        end else if (rx_hit_i) begin
          state_d = ST_DONE;
          cap_o   = 1'b1;
        end else if (sat_i) begin
          state_d  = ST_DONE;
          cap_o    = 1'b1;
          cap_to_o = 1'b1;
        end
      end
      ST_DONE: begin
        if (rearm) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= enable_i;
      if (cap_o)                   to_q <= cap_to_o;
      else if (state_d != ST_DONE) to_q <= 1'b0;
    end
  end

  assign busy_o    = (state_q == ST_COUNT);
  assign valid_o   = (state_q == ST_DONE) && !to_q;
  assign timeout_o = to_q;

  assert_idle_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !enable_i) |=> (state_q == ST_IDLE));

  assert_stop_on_rx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COUNT && enable_i && !clear_i && rx_hit_i) |=> (valid_o && !busy_o));

  assert_tx_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COUNT && enable_i && !clear_i && !rx_hit_i && !sat_i) |=> busy_o);

  assert_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !enable_i) |=> (state_q == ST_IDLE));

  assert_flags_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, valid_o, timeout_o}));
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             cap_i,
  input  logic             cap_to_i,
  output logic             sat_o,
  output logic [CNT_W-1:0] result_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] res_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_ONE;
  assign sat_o   = (cnt_inc == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      res_q <= '0;
    end else begin
      if (start_i)    cnt_q <= '0;
      else if (run_i) cnt_q <= cnt_inc;
      if (cap_i)      res_q <= cap_to_i ? CNT_MAX : cnt_inc;
    end
  end

  assign result_o = res_q;

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(res_q));
endmodule

// File: rtl/rtt_regs.sv
module rtt_regs #(
  parameter int CNT_W = 20
) (
  input  logic             rd_addr_i,
  input  logic [CNT_W-1:0] result_i,
  input  logic             busy_i,
  input  logic             valid_i,
  input  logic             timeout_i,
  output logic [CNT_W-1:0] rd_data_o
);
  logic [CNT_W-1:0] status_word;

  always_comb begin
    status_word      = '0;
    status_word[0]   = busy_i;
    status_word[1]   = valid_i;
    status_word[2]   = timeout_i;
  end

  assign rd_data_o = rd_addr_i ? status_word : result_i;
endmodule

// File: rtl/rtt_latency_meter.sv
module rtt_latency_meter
  import rtt_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              clear_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_k_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_k_i,
  input  logic              rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic              timeout_o,
  output logic [CNT_W-1:0]  result_o
);
  localparam logic [CNT_W-1:0] RES_MAX = '1;

  logic tx_hit, rx_hit, sat, start, cap, cap_to;

  rtt_comma_det #(.DATA_W(BYTE_W), .CODE(COMMA_BYTE)) u_tx_det (
    .data_i(tx_data_i), .k_i(tx_k_i), .hit_o(tx_hit)
  );

  rtt_comma_det #(.DATA_W(BYTE_W), .CODE(COMMA_BYTE)) u_rx_det (
    .data_i(rx_data_i), .k_i(rx_k_i), .hit_o(rx_hit)
  );

  rtt_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .clear_i  (clear_i),
    .tx_hit_i (tx_hit),
    .rx_hit_i (rx_hit),
    .sat_i    (sat),
    .start_o  (start),
    .cap_o    (cap),
    .cap_to_o (cap_to),
    .busy_o   (busy_o),
    .valid_o  (valid_o),
    .timeout_o(timeout_o)
  );

  rtt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (busy_o),
    .cap_i   (cap),
    .cap_to_i(cap_to),
    .sat_o   (sat),
    .result_o(result_o)
  );

  rtt_regs #(.CNT_W(CNT_W)) u_regs (
    .rd_addr_i(rd_addr_i),
    .result_i (result_o),
    .busy_i   (busy_o),
    .valid_i  (valid_o),
    .timeout_i(timeout_o),
    .rd_data_o(rd_data_o)
  );

  assert_start_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !valid_o && !timeout_o && enable_i && !clear_i && tx_k_i && tx_data_i == COMMA_BYTE)
    |=> busy_o);

  assert_timeout_all_ones_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (result_o == RES_MAX && !valid_o));

  assert_clear_rearms_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !busy_o) |=> (!busy_o && !valid_o && !timeout_o));
endmodule

// File: tb/rtt_latency_meter_bench.sv
module rtt_latency_meter_bench;
  localparam int CNT_W = 6;
  localparam int MAXV  = (1 << CNT_W) - 1;
  localparam int NV    = 6;
  // gap (b-a), receive comma also at start cycle, cycle of extra transmit comma (0 = none)
  localparam int V_GAP [NV] = '{1, 2, 7, 20, 45, 62};
  localparam int V_SAME[NV] = '{1, 0, 1, 0, 0, 1};
  localparam int V_DUP [NV] = '{0, 0, 3, 10, 0, 30};

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             enable_i = 1'b0, clear_i = 1'b0;
  logic [7:0]       tx_data_i = 8'h55, rx_data_i = 8'h55;
  logic             tx_k_i = 1'b0, rx_k_i = 1'b0;
  logic             rd_addr_i = 1'b0;
  logic [CNT_W-1:0] rd_data_o, result_o;
  logic             busy_o, valid_o, timeout_o;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  rtt_latency_meter #(.CNT_W(CNT_W)) u_rtt_latency_meter (
    .clk_i, .rst_ni, .enable_i, .clear_i, .tx_data_i, .tx_k_i,
    .rx_data_i, .rx_k_i, .rd_addr_i, .rd_data_o, .busy_o,
    .valid_o, .timeout_o, .result_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_tx(bit c);
    tx_k_i = c; tx_data_i = c ? 8'hBC : 8'h55;
  endtask

  task automatic set_rx(bit c);
    rx_k_i = c; rx_data_i = c ? 8'hBC : 8'h55;
  endtask

  task automatic pulse_clear();
    @(negedge clk_i); clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
  endtask

  task automatic run_meas(int gap, bit same, int dup);
    @(negedge clk_i); set_tx(1'b1); set_rx(same);
    for (int c = 1; c <= gap; c++) begin
      @(negedge clk_i);
      chk("R4 busy while counting", busy_o, 1);
      set_tx(c == dup); set_rx(c == gap);
    end
    @(negedge clk_i);
    chk("R5 valid", valid_o, 1);
    chk("R5 busy low", busy_o, 0);
    chk("R5 R7 result", result_o, gap);
    rd_addr_i = 1'b0; #0;
    chk("R13 result word", rd_data_o, gap);
    set_tx(1'b0); set_rx(1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy", busy_o, 0);
    chk("R1 valid", valid_o, 0);
    chk("R1 timeout", timeout_o, 0);
    chk("R1 result", result_o, 0);
    rd_addr_i = 1'b1; #0;
    chk("R1 R13 status", rd_data_o, 0);
    rd_addr_i = 1'b0;

    // R3: disabled
    set_tx(1'b1);
    @(negedge clk_i); set_tx(1'b0);
    chk("R3 no start when disabled", busy_o, 0);

    // R2: near-miss codes
    enable_i = 1'b1;
    tx_k_i = 1'b0; tx_data_i = 8'hBC;
    @(negedge clk_i);
    chk("R2 unflagged BC", busy_o, 0);
    tx_k_i = 1'b1; tx_data_i = 8'h3C;
    @(negedge clk_i);
    chk("R2 K28.1", busy_o, 0);
    set_tx(1'b0);

    // R6: receive comma while idle
    set_rx(1'b1);
    @(negedge clk_i); set_rx(1'b0);
    chk("R6 idle rx busy", busy_o, 0);
    chk("R6 idle rx valid", valid_o, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      pulse_clear();
      run_meas(V_GAP[i], V_SAME[i] != 0, V_DUP[i]);
    end

    // R8: timeout
    pulse_clear();
    @(negedge clk_i); set_tx(1'b1);
    for (int c = 1; c <= MAXV; c++) begin
      @(negedge clk_i);
      if (c == MAXV) chk("R8 still busy at limit-1", busy_o, 1);
      set_tx(1'b0);
    end
    @(negedge clk_i);
    chk("R8 timeout", timeout_o, 1);
    chk("R8 valid low", valid_o, 0);
    chk("R8 result all ones", result_o, MAXV);
    chk("R12 busy low", busy_o, 0);
    rd_addr_i = 1'b1; #0;
    chk("R13 status timeout", rd_data_o, 4);
    rd_addr_i = 1'b0;

    // R9: clear keeps result, clear beats start
    clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
    chk("R9 timeout cleared", timeout_o, 0);
    chk("R9 result kept", result_o, MAXV);
    clear_i = 1'b1; set_tx(1'b1);
    @(negedge clk_i); clear_i = 1'b0; set_tx(1'b0);
    chk("R9 clear blocks start", busy_o, 0);

    // R10: enable rise rearms
    run_meas(4, 1'b0, 0);
    enable_i = 1'b0;
    @(negedge clk_i);
    chk("R10 valid kept while disabled", valid_o, 1);
    enable_i = 1'b1;
    @(negedge clk_i);
    chk("R10 rearmed", valid_o, 0);
    chk("R10 result kept", result_o, 4);
    rd_addr_i = 1'b1; #0;
    chk("R13 status idle", rd_data_o, 0);
    rd_addr_i = 1'b0;

    // R11: abort
    set_tx(1'b1);
    @(negedge clk_i); set_tx(1'b0);
    chk("R11 started", busy_o, 1);
    rd_addr_i = 1'b1; #0;
    chk("R13 status busy", rd_data_o, 1);
    rd_addr_i = 1'b0;
    enable_i = 1'b0;
    @(negedge clk_i);
    chk("R11 busy dropped", busy_o, 0);
    chk("R11 valid low", valid_o, 0);
    chk("R11 result kept", result_o, 4);
    enable_i = 1'b1;

    @(negedge clk_i);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule